// File: doc/BRIEF.md
# Sprite Line Latch and Pixel Serializer

This block is the display half of one sprite channel. Two data words make up a sprite line. Each arrives as a register write, from a DMA slot or from a CPU store. The block also takes writes to the two control words, which are the position word and the control word. It holds an armed flag and two data latches. When the beam's horizontal counter reaches the programmed start column, it sends the latched line out as a run of 2-bit colour indices, where index 0 means transparent.

Arming comes only from a write to the first data word. Disarming comes only from a write to the control word. A channel that is armed therefore redraws its latched line on every scanline, even after fetching has stopped, until a control write disarms it. If a slot is skipped, the latch on that side keeps its previous contents. If the first-data slot is missed, that line does not arm the channel.

Top module: `spr_line_unit`

## Requirements
- R1: After reset the channel is disarmed, both data latches and both control words hold zero, and `pix_idx` is 0.
- R2: A write with `wr_sel`=2 (first data word) stores `wr_data` in latch A and arms the channel from the next cycle.
- R3: A write with `wr_sel`=1 (control word) disarms the channel. A write with `wr_sel`=0 (position word) leaves the armed state unchanged.
- R4: A write with `wr_sel`=3 (second data word) stores `wr_data` in latch B only. It neither arms nor disarms the channel and leaves latch A unchanged.
- R5: The 9-bit start column is {position word bits 7:0, control word bit 0}. No other counter value starts a line.
- R6: When the channel is armed and `hcount` equals the start column, 16 pixels follow on the next 16 cycles. Pixel i is {B[15-i], A[15-i]}, so the data goes out MSB first and latch B supplies the high bit of the index. After the 16th pixel the output returns to 0.
- R7: While the channel is disarmed and no run is in progress, `pix_idx` is 0 at every counter value.
- R8: An armed channel replays the same latched line on each later scanline, with no further data writes.
- R9: If one data write of a line is skipped, the run uses the earlier contents of that side's latch.
- R10: A line that writes only the second data word does not arm a disarmed channel.
- R11: A control write during a run does not cut the run short. The 16 pixels finish, and no later line starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hcount | input | 9 | Beam horizontal counter |
| wr_en | input | 1 | Register write strobe (DMA slot or CPU store) |
| wr_sel | input | 2 | Target: 0 position, 1 control, 2 data A, 3 data B |
| wr_data | input | 16 | Write data |
| pix_idx | output | 2 | Colour index of the current pixel, 0 = transparent |

## Verification
The assertions assume that at most one register write arrives per cycle and that `wr_sel` always carries one of the four defined codes. The stimulus drives writes one at a time through a single task, so two writes never coincide. The assertions also assume that `hcount` does not return to the start column while a run is still in progress. The bench enforces this by moving the counter away from the start column in the cycle after each start and keeping it away until the run has ended.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int DW = 16;
    localparam int HW = 9;

    typedef enum logic [1:0] {
        SEL_POS   = 2'd0,
        SEL_CTL   = 2'd1,
        SEL_DATAA = 2'd2,
        SEL_DATAB = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic          en;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } reg_wr_t;

    function automatic logic [HW-1:0] start_col(input logic [DW-1:0] pos,
                                                input logic [DW-1:0] ctl);
        return {pos[HW-2:0], ctl[0]};
    endfunction
endpackage

// File: rtl/spr_ctrl_regs.sv
module spr_ctrl_regs
    import spr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  reg_wr_t       wr,
    output logic [HW-1:0] hstart,
    output logic          armed
);
    logic [DW-1:0] pos_q, ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            ctl_q <= '0;
            armed <= 1'b0;
        end else if (wr.en) begin
            case (wr.sel)
                SEL_POS:   pos_q <= wr.data;
                SEL_CTL: begin
                    ctl_q <= wr.data;
                    armed <= 1'b0;
                end
                SEL_DATAA: armed <= 1'b1;
                default:   ;
            endcase
        end
    end

    assign hstart = start_col(pos_q, ctl_q);

    p_arm_on_first_word_r2: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == SEL_DATAA) |=> armed);
    p_disarm_on_ctl_r3: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == SEL_CTL) |=> !armed);
    p_arm_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr.en || wr.sel == SEL_POS || wr.sel == SEL_DATAB) |=> $stable(armed));
endmodule

// File: rtl/spr_data_latch.sv
module spr_data_latch
    import spr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  reg_wr_t       wr,
    output logic [DW-1:0] lat_a,
    output logic [DW-1:0] lat_b
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_a <= '0;
            lat_b <= '0;
        end else if (wr.en) begin
            if (wr.sel == SEL_DATAA) lat_a <= wr.data;
            if (wr.sel == SEL_DATAB) lat_b <= wr.data;
        end
    end

    p_a_kept_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr.en && wr.sel == SEL_DATAA) |=> $stable(lat_a));
    p_b_kept_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr.en && wr.sel == SEL_DATAB) |=> $stable(lat_b));
endmodule

// File: rtl/spr_serializer.sv
module spr_serializer
    import spr_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic [1:0]   pix
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh_a, sh_b;
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_a <= '0;
            sh_b <= '0;
            left <= '0;
        end else if (start) begin
            sh_a <= src_a;
            sh_b <= src_b;
            left <= CW'(W);
        end else if (left != '0) begin
            sh_a <= {sh_a[W-2:0], 1'b0};
            sh_b <= {sh_b[W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign pix = (left != '0) ? {sh_b[W-1], sh_a[W-1]} : 2'b00;

    p_run_loads_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> (left == CW'(W)));
    p_run_counts_down_r11: assert property (@(posedge clk) disable iff (rst)
        (!start && left != '0) |=> (left == $past(left) - 1'b1));
    always_comb begin
        if (!rst) p_left_bound_r6: assert (left <= CW'(W));
    end
endmodule

// File: rtl/spr_line_unit.sv
module spr_line_unit
    import spr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] hcount,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [1:0]    pix_idx
);
    reg_wr_t       wr;
    logic [HW-1:0] hstart;
    logic          armed;
    logic [DW-1:0] lat_a, lat_b;
    logic          line_go;

    assign wr.en   = wr_en;
    assign wr.sel  = reg_sel_e'(wr_sel);
    assign wr.data = wr_data;

    spr_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .wr(wr), .hstart(hstart), .armed(armed)
    );

    spr_data_latch u_latch (
        .clk(clk), .rst(rst), .wr(wr), .lat_a(lat_a), .lat_b(lat_b)
    );

    assign line_go = armed && (hcount == hstart);

    spr_serializer #(.W(DW)) u_ser (
        .clk(clk), .rst(rst), .start(line_go),
        .src_a(lat_a), .src_b(lat_b), .pix(pix_idx)
    );

    p_reset_dark_r1: assert property (@(posedge clk)
        rst |=> (pix_idx == 2'b00));
endmodule

// File: tb/spr_line_unit_test.sv
module spr_line_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  hcount;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [1:0]  pix_idx;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    spr_line_unit uut (
        .clk(clk), .rst(rst), .hcount(hcount), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pix_idx(pix_idx)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive one line's start column and compare the 17 outputs that follow.
    // ctl_at >= 0 issues a control write right after that pixel is sampled.
    task automatic run_line(input string req, input logic [8:0] hs,
                            input logic [15:0] ea, input logic [15:0] eb,
                            input logic on, input int ctl_at);
        @(negedge clk);
        hcount = hs;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            hcount = hs ^ 9'h100;
            check(req, pix_idx, on ? {eb[15-i], ea[15-i]} : 2'b00);
            if (i == ctl_at) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h0001;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        check(req, pix_idx, 2'b00);
    endtask

    task automatic t_reset();
        for (int h = 0; h < 8; h++) begin
            @(negedge clk);
            hcount = 9'(h);
            check("R1", pix_idx, 2'b00);
        end
    endtask

    task automatic t_basic();
        wr_reg(2'd0, 16'h0020);
        wr_reg(2'd1, 16'h0001);          // start column 0x041
        run_line("R5 not armed yet", 9'h041, 16'h0, 16'h0, 1'b0, -1);
        wr_reg(2'd2, 16'hA5F0);
        wr_reg(2'd3, 16'h0FF0);
        run_line("R5 wrong column", 9'h040, 16'h0, 16'h0, 1'b0, -1);
        run_line("R2 R4 R6 line", 9'h041, 16'hA5F0, 16'h0FF0, 1'b1, -1);
    endtask

    task automatic t_repeat();
        run_line("R8 replay 1", 9'h041, 16'hA5F0, 16'h0FF0, 1'b1, -1);
        run_line("R8 replay 2", 9'h041, 16'hA5F0, 16'h0FF0, 1'b1, -1);
    endtask

    task automatic t_disarm();
        wr_reg(2'd1, 16'h0001);
        run_line("R3 R7 disarmed", 9'h041, 16'h0, 16'h0, 1'b0, -1);
        wr_reg(2'd0, 16'h0020);
        run_line("R3 pos write no arm", 9'h041, 16'h0, 16'h0, 1'b0, -1);
    endtask

    task automatic t_missed_first();
        wr_reg(2'd3, 16'hFFFF);
        run_line("R10 only B written", 9'h041, 16'h0, 16'h0, 1'b0, -1);
    endtask

    task automatic t_skip_b();
        wr_reg(2'd2, 16'h3C3C);          // B slot skipped: B stays 0xFFFF
        run_line("R9 stale B", 9'h041, 16'h3C3C, 16'hFFFF, 1'b1, -1);
        wr_reg(2'd3, 16'h8001);
        run_line("R4 B only updated", 9'h041, 16'h3C3C, 16'h8001, 1'b1, -1);
    endtask

    task automatic t_new_column();
        wr_reg(2'd0, 16'h00FF);
        wr_reg(2'd1, 16'h0000);          // start column 0x1FE, disarmed
        wr_reg(2'd2, 16'h1234);
        run_line("R5 high column", 9'h1FE, 16'h1234, 16'h8001, 1'b1, -1);
    endtask

    task automatic t_midline_ctl();
        run_line("R11 run completes", 9'h1FE, 16'h1234, 16'h8001, 1'b1, 3);
        run_line("R11 no next line", 9'h1FE, 16'h0, 16'h0, 1'b0, -1);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; hcount = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_repeat();
        t_disarm();
        t_missed_first();
        t_skip_b();
        t_new_column();
        t_midline_ctl();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule